// File: doc/BRIEF.md
# NAND Target Command and Address Front End

This block sits on the device side of a byte-wide NAND flash target. The host drives it with single-cycle strobes: a command chunk, an address chunk, a data write or a data read, with an 8-bit value on a shared input bus. The block keeps the opening command, a second (confirm) command and an address pointer. A command chunk preloads the pointer, so each operation expects its own number of address chunks. Those chunks are packed into a column address and a row address. The row address carries the page, block and LUN fields.

After an operation is confirmed, data bytes move between the bus and a 2048-byte page register held in inferable block RAM. The transfer starts at the loaded column and advances by one byte per transfer. A status read instead returns a byte built from the ready and fail inputs of the LUN that the last confirmed operation selected. Those inputs stand in for the array and its timing. A chunk that arrives when its guard is closed changes nothing and sets a sticky protocol-error flag.

Top module: `nand_cmd_frontend`

## Requirements
- R1: After reset the opening and confirm commands both hold Reset, the pointer is 5 (no address expected), proto_err and dout_valid are 0, and fld_page, fld_block and fld_lun are 0.
- R2: Command byte codes are Reset 8'hFF, Status 8'h70, Read 8'h00, Program 8'h80 and Erase 8'h60. When one of these is taken as an opening command, confirm is cleared. Read and Program set the pointer to 0 (five address chunks expected). Erase sets it to 2 (the three row chunks only). Status and Reset set it to 5.
- R3: An address chunk is taken only while the pointer is below 5. It fills chunk slot number pointer, and the pointer then increments. Otherwise the chunk is ignored and proto_err is set.
- R4: Chunks arrive least significant first. Column = {chunk1[2:0], chunk0}. Row = {chunk4[2:0], chunk3, chunk2}. fld_page = row[5:0], fld_block = row[16:6] and fld_lun = row[18:17].
- R5: A command chunk is taken as the confirm when the pointer is 5, the opening command is Read, Program or Erase, and confirm is Reset. Its code then becomes the confirm, and the current fld_lun becomes the active LUN. The Reset byte always acts as an opening command.
- R6: A data write is taken only while confirm holds Program. The byte is stored at the current column, and the column then increments. Otherwise the write is ignored and proto_err is set.
- R7: A data read while confirm holds Read returns the byte at the current column on dout. dout_valid is 1 in the cycle after the strobe. The column then increments.
- R8: A data read while the opening command or the confirm is Status returns {1'b0, lun_ready[a], 5'b0, lun_fail[a]}, where a is the active LUN. The column does not move.
- R9: An unknown command byte, or a read that neither R7 nor R8 allows, is ignored. In that case dout_valid stays 0 and proto_err is set. Once set, proto_err stays 1 until rst.
- R10: When several strobes are high in one cycle, only the highest one is acted on, in the order command, address, write, read. The others are ignored and proto_err is set.
- R11: The column wraps from 2047 to 0 on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command chunk strobe |
| addr_stb | input | 1 | Address chunk strobe |
| wr_stb | input | 1 | Data-write strobe |
| rd_stb | input | 1 | Data-read strobe |
| din | input | 8 | Chunk value from the host |
| lun_ready | input | 4 | Ready flag per LUN |
| lun_fail | input | 4 | Fail flag per LUN |
| dout | output | 8 | Read data or status byte |
| dout_valid | output | 1 | dout holds the result of a read taken in the previous cycle |
| proto_err | output | 1 | Sticky protocol-error flag |
| fld_page | output | 6 | Page field of the row address |
| fld_block | output | 11 | Block field of the row address |
| fld_lun | output | 2 | LUN field of the row address |

## Verification
A command chunk and a data read can be raised in the same cycle. This is provoked after a Read has been confirmed, by driving a Status command and a read strobe together. The bench judges that the command won by checking three things. No read data appears in the next cycle. proto_err rises. A later lone read returns the status byte rather than page data.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  localparam int BYTE_W = 8;
  localparam int NCHUNK = 5;
  localparam int PTR_W  = 3;

  typedef enum logic [2:0] {OP_RESET, OP_STATUS, OP_READ, OP_PROG, OP_ERASE} op_e;

  localparam logic [7:0] CODE_RESET  = 8'hFF;
  localparam logic [7:0] CODE_STATUS = 8'h70;
  localparam logic [7:0] CODE_READ   = 8'h00;
  localparam logic [7:0] CODE_PROG   = 8'h80;
  localparam logic [7:0] CODE_ERASE  = 8'h60;

  function automatic logic code_known(input logic [7:0] b);
    return (b == CODE_RESET) || (b == CODE_STATUS) || (b == CODE_READ) ||
           (b == CODE_PROG) || (b == CODE_ERASE);
  endfunction

  function automatic op_e code_op(input logic [7:0] b);
    case (b)
      CODE_STATUS: return OP_STATUS;
      CODE_READ:   return OP_READ;
      CODE_PROG:   return OP_PROG;
      CODE_ERASE:  return OP_ERASE;
      default:     return OP_RESET;
    endcase
  endfunction
endpackage

// File: rtl/nfe_cmd_ctrl.sv
module nfe_cmd_ctrl
  import nfe_pkg::*;
#(
  parameter int COL_W  = 11,
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 11,
  parameter int LUN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              addr_stb,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [7:0]        din,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] fld_page,
  output logic [BLK_W-1:0]  fld_block,
  output logic [LUN_W-1:0]  fld_lun,
  output logic [LUN_W-1:0]  act_lun,
  output logic              wr_ok,
  output logic              rd_page,
  output logic              rd_stat,
  output logic              proto_err
);
  localparam int ROW_W  = PAGE_W + BLK_W + LUN_W;
  localparam int COL_CH = (COL_W + BYTE_W - 1) / BYTE_W;
  localparam logic [PTR_W-1:0] PTR_FULL  = PTR_W'(NCHUNK);
  localparam logic [PTR_W-1:0] PTR_ERASE = PTR_W'(COL_CH);

  op_e              cmd_q, conf_q, dop;
  logic [PTR_W-1:0] ptr_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LUN_W-1:0] act_q;
  logic             err_q;
  logic             multi, take_cmd, take_addr, take_wr, take_rd;
  logic             known, conf_open, addr_ok, bad;

  assign multi     = (cmd_stb & (addr_stb | wr_stb | rd_stb)) |
                     (addr_stb & (wr_stb | rd_stb)) | (wr_stb & rd_stb);
  assign take_cmd  = cmd_stb;
  assign take_addr = addr_stb & ~cmd_stb;
  assign take_wr   = wr_stb & ~cmd_stb & ~addr_stb;
  assign take_rd   = rd_stb & ~cmd_stb & ~addr_stb & ~wr_stb;

  assign known     = code_known(din);
  assign dop       = code_op(din);
  assign conf_open = (ptr_q == PTR_FULL) && (conf_q == OP_RESET) &&
                     (cmd_q inside {OP_READ, OP_PROG, OP_ERASE});
  assign addr_ok   = take_addr && (ptr_q < PTR_FULL);
  assign wr_ok     = take_wr && (conf_q == OP_PROG);
  assign rd_page   = take_rd && (conf_q == OP_READ);
  assign rd_stat   = take_rd && !rd_page && (conf_q == OP_STATUS || cmd_q == OP_STATUS);
  assign bad       = multi | (take_cmd & ~known) | (take_addr & ~addr_ok) |
                     (take_wr & ~wr_ok) | (take_rd & ~(rd_page | rd_stat));

  assign col       = col_q;
  assign fld_page  = row_q[PAGE_W-1:0];
  assign fld_block = row_q[PAGE_W +: BLK_W];
  assign fld_lun   = row_q[PAGE_W+BLK_W +: LUN_W];
  assign act_lun   = act_q;
  assign proto_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= OP_RESET;
      conf_q <= OP_RESET;
      ptr_q  <= PTR_FULL;
      col_q  <= '0;
      row_q  <= '0;
      act_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (bad) err_q <= 1'b1;
      if (take_cmd && known) begin
        if (dop == OP_RESET) begin
          cmd_q  <= OP_RESET;
          conf_q <= OP_RESET;
          ptr_q  <= PTR_FULL;
        end else if (conf_open) begin
          conf_q <= dop;
          act_q  <= fld_lun;
        end else begin
          cmd_q  <= dop;
          conf_q <= OP_RESET;
          case (dop)
            OP_STATUS: ptr_q <= PTR_FULL;
            OP_ERASE:  ptr_q <= PTR_ERASE;
            default:   ptr_q <= '0;
          endcase
        end
      end
      if (addr_ok) begin
        ptr_q <= ptr_q + 1'b1;
        for (int i = 0; i < COL_W; i++)
          if (i / BYTE_W == int'(ptr_q)) col_q[i] <= din[i % BYTE_W];
        for (int i = 0; i < ROW_W; i++)
          if (i / BYTE_W + COL_CH == int'(ptr_q)) row_q[i] <= din[i % BYTE_W];
      end
      if (wr_ok || rd_page) col_q <= col_q + 1'b1;
    end
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst) ptr_q <= PTR_FULL);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_ok && !cmd_stb) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R2
  erase_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && din == CODE_ERASE && !conf_open) |=> ptr_q == PTR_ERASE);
  // R6
  wr_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (take_wr && conf_q != OP_PROG) |=> err_q);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q);
endmodule

// File: rtl/nfe_page_ram.sv
module nfe_page_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nfe_stat_sel.sv
module nfe_stat_sel #(
  parameter int LUN_W = 2,
  parameter int NLUN  = 1 << LUN_W
) (
  input  logic [NLUN-1:0]  ready,
  input  logic [NLUN-1:0]  fail,
  input  logic [LUN_W-1:0] sel,
  output logic [7:0]       stat
);
  logic [7:0] per_lun [NLUN];

  for (genvar g = 0; g < NLUN; g++) begin : g_lun
    assign per_lun[g] = {1'b0, ready[g], 5'b00000, fail[g]};
  end

  assign stat = per_lun[sel];
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nfe_pkg::*;
#(
  parameter int COL_W  = 11,
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 11,
  parameter int LUN_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_stb,
  input  logic                 addr_stb,
  input  logic                 wr_stb,
  input  logic                 rd_stb,
  input  logic [7:0]           din,
  input  logic [(1<<LUN_W)-1:0] lun_ready,
  input  logic [(1<<LUN_W)-1:0] lun_fail,
  output logic [7:0]           dout,
  output logic                 dout_valid,
  output logic                 proto_err,
  output logic [PAGE_W-1:0]    fld_page,
  output logic [BLK_W-1:0]     fld_block,
  output logic [LUN_W-1:0]     fld_lun
);
  localparam int NLUN = 1 << LUN_W;

  logic [COL_W-1:0] col;
  logic [LUN_W-1:0] act_lun;
  logic             wr_ok, rd_page, rd_stat;
  logic [7:0]       ram_q, stat_now, stat_q;
  logic             vld_q, ssel_q;

  nfe_cmd_ctrl #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .LUN_W(LUN_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .din(din), .col(col), .fld_page(fld_page), .fld_block(fld_block),
    .fld_lun(fld_lun), .act_lun(act_lun), .wr_ok(wr_ok), .rd_page(rd_page),
    .rd_stat(rd_stat), .proto_err(proto_err)
  );

  nfe_page_ram #(.AW(COL_W), .DW(8)) u_ram (
    .clk(clk), .we(wr_ok), .addr(col), .wdata(din), .rdata(ram_q)
  );

  nfe_stat_sel #(.LUN_W(LUN_W), .NLUN(NLUN)) u_stat (
    .ready(lun_ready), .fail(lun_fail), .sel(act_lun), .stat(stat_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      ssel_q <= 1'b0;
      stat_q <= '0;
    end else begin
      vld_q  <= rd_page | rd_stat;
      ssel_q <= rd_stat;
      if (rd_stat) stat_q <= stat_now;
    end
  end

  assign dout       = ssel_q ? stat_q : ram_q;
  assign dout_valid = vld_q;

  // R7
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(rd_stb));
  // R10
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && rd_stb) |=> (!dout_valid && proto_err));
endmodule

// File: tb/tb_nand_cmd_frontend.sv
module tb_nand_cmd_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_stb = 0, addr_stb = 0, wr_stb = 0, rd_stb = 0;
  logic [7:0] din = '0;
  logic [3:0] lun_ready = '0, lun_fail = '0;
  logic [7:0] dout;
  logic dout_valid, proto_err;
  logic [5:0] fld_page;
  logic [10:0] fld_block;
  logic [1:0] fld_lun;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nand_cmd_frontend dut (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .din(din), .lun_ready(lun_ready), .lun_fail(lun_fail),
    .dout(dout), .dout_valid(dout_valid), .proto_err(proto_err),
    .fld_page(fld_page), .fld_block(fld_block), .fld_lun(fld_lun)
  );

  localparam logic [1:0] V_CMD = 2'd0, V_ADR = 2'd1, V_WR = 2'd2, V_RD = 2'd3;
  typedef struct packed { logic [1:0] op; logic [7:0] val; } vec_t;
  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{V_CMD, 8'h80}, '{V_ADR, 8'h05}, '{V_ADR, 8'h00}, '{V_ADR, 8'h00}, '{V_ADR, 8'h00},
    '{V_ADR, 8'h00}, '{V_CMD, 8'h80}, '{V_WR, 8'hA1}, '{V_WR, 8'hB2}, '{V_WR, 8'hC3},
    '{V_CMD, 8'h00}, '{V_ADR, 8'h05}, '{V_ADR, 8'h00}, '{V_ADR, 8'h00}, '{V_ADR, 8'h00},
    '{V_ADR, 8'h00}, '{V_CMD, 8'h00}, '{V_RD, 8'hA1}, '{V_RD, 8'hB2}, '{V_RD, 8'hC3},
    '{V_CMD, 8'h70}, '{V_RD, 8'h40}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, a, w, r, input logic [7:0] v);
    @(negedge clk);
    cmd_stb = c; addr_stb = a; wr_stb = w; rd_stb = r; din = v;
    @(negedge clk);
    cmd_stb = 0; addr_stb = 0; wr_stb = 0; rd_stb = 0;
  endtask

  task automatic cmd(input logic [7:0] v); drive(1, 0, 0, 0, v); endtask
  task automatic adr(input logic [7:0] v); drive(0, 1, 0, 0, v); endtask
  task automatic wrb(input logic [7:0] v); drive(0, 0, 1, 0, v); endtask

  task automatic rd_expect(input logic [7:0] exp, input string req);
    drive(0, 0, 0, 1, 8'h00);
    check(dout_valid === 1'b1 && dout === exp, req, {23'd0, dout_valid, dout}, {24'd1, exp});
  endtask

  task automatic open5(input logic [7:0] code, input logic [7:0] c0, input logic [7:0] c1);
    cmd(code); adr(c0); adr(c1); adr(8'h00); adr(8'h00); adr(8'h00);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    lun_ready = 4'b0001;
    do_reset;
    // R1 reset state
    check(dout_valid === 1'b0 && proto_err === 1'b0, "R1 flags", {dout_valid, proto_err}, 0);
    check(fld_page === 0 && fld_block === 0 && fld_lun === 0, "R1 fields",
          {fld_lun, fld_block, fld_page}, 0);
    // R1 / R3: pointer starts at 5, so an address chunk is refused
    adr(8'h12);
    check(proto_err === 1'b1, "R3 addr after reset", proto_err, 1);

    // R2 R6 R7 R8: vector table
    do_reset;
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        V_CMD: cmd(VEC[i].val);
        V_ADR: adr(VEC[i].val);
        V_WR:  wrb(VEC[i].val);
        default: rd_expect(VEC[i].val, "R7 table read");
      endcase
    end
    check(proto_err === 1'b0, "R2 table no error", proto_err, 0);

    // R4 R2: erase takes only row chunks
    do_reset;
    cmd(8'h60); adr(8'hEA); adr(8'h45); adr(8'h05);
    check(fld_page === 6'h2A, "R4 page", fld_page, 6'h2A);
    check(fld_block === 11'h517, "R4 block", fld_block, 11'h517);
    check(fld_lun === 2'd2 && proto_err === 1'b0, "R4 lun", {proto_err, fld_lun}, 2);
    adr(8'h99);
    check(proto_err === 1'b1 && fld_page === 6'h2A && fld_lun === 2'd2, "R3 extra chunk",
          {proto_err, fld_lun, fld_page}, {1'b1, 2'd2, 6'h2A});

    // R5 R8: erase confirm picks LUN 2 for status
    cmd(8'h60); cmd(8'h70);
    lun_ready = 4'b0100; lun_fail = 4'b0100;
    rd_expect(8'h41, "R8 status lun2 ready+fail");
    lun_ready = 4'b1011; lun_fail = 4'b1011;
    rd_expect(8'h00, "R5 status follows active lun");

    // R6 R9: write before confirm is ignored, column unmoved
    do_reset;
    open5(8'h80, 8'h20, 8'h00);
    wrb(8'h55);
    check(proto_err === 1'b1, "R6 write refused", proto_err, 1);
    cmd(8'h80); wrb(8'h66);
    open5(8'h00, 8'h20, 8'h00); cmd(8'h00);
    rd_expect(8'h66, "R6 ignored write left no trace");

    // R11 column wrap
    do_reset;
    open5(8'h80, 8'hFF, 8'h07); cmd(8'h80); wrb(8'h11); wrb(8'h22);
    open5(8'h00, 8'h00, 8'h00); cmd(8'h00);
    rd_expect(8'h22, "R11 wrapped write at 0");
    open5(8'h00, 8'hFF, 8'h07); cmd(8'h00);
    rd_expect(8'h11, "R11 read at 2047");
    rd_expect(8'h22, "R11 read wraps to 0");
    check(proto_err === 1'b0, "R11 no error", proto_err, 0);

    // R9 unknown command and refused read
    do_reset;
    cmd(8'h3C);
    check(proto_err === 1'b1, "R9 unknown command", proto_err, 1);
    drive(0, 0, 0, 1, 8'h00);
    check(dout_valid === 1'b0, "R9 read refused", dout_valid, 0);

    // R10 command and read in one cycle
    do_reset;
    lun_ready = 4'b0001; lun_fail = 4'b0000;
    open5(8'h00, 8'h05, 8'h00); cmd(8'h00);
    drive(1, 0, 0, 1, 8'h70);
    check(dout_valid === 1'b0 && proto_err === 1'b1, "R10 read dropped",
          {dout_valid, proto_err}, 1);
    rd_expect(8'h40, "R10 command won");

    // R5 Reset byte restarts mid-address
    do_reset;
    cmd(8'h00); adr(8'h01); cmd(8'hFF);
    check(proto_err === 1'b0, "R5 reset byte accepted", proto_err, 0);
    adr(8'h02);
    check(proto_err === 1'b1, "R5 pointer full after reset byte", proto_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule